// File: doc/BRIEF.md
# I2C Controller Status Flags

This block keeps the mode and status flags of a two-wire serial bus controller: master or slave role, transmit or receive direction, bus busy, the per-byte pending flag and arbitration lost. A separate bus monitor reports events as single-cycle strobes, and the CPU writes the status fields or the data shift register. From these the block updates its flags, raises an interrupt when a byte finishes, asks the clock generator to hold SCL low while software services the byte, and emits or blocks a START request.

The flags clear themselves on bus events and act on each other. When arbitration is lost, the direction bit drops in that same cycle, but the master role stays until the byte in progress has completed. The block therefore falls back to slave receive in time to recognise its own address from the winning master. A START that software requests while the bus is already busy is suppressed. The suppression resets the role and direction and releases the pending flag.

Top module: `i2c_flag_ctrl`

## Requirements
- R1: When `mst_o`=1, `trx_o`=1 and `sda_mismatch` is strobed, `arb_lost_o` reads 1 and `trx_o` reads 0 after that clock edge. `arb_lost_o` resets to 0 and is cleared by an accepted START request (R11).
- R2: After arbitration is lost, `mst_o` stays 1 until a `byte_done` strobe. `mst_o` reads 0 after the clock edge of that strobe.
- R3: A loss during the address byte leaves the block in slave receive mode (`mst_o`=0, `trx_o`=0) once that byte completes.
- R4: A `byte_done` strobe drives `pend_o` from 1 to 0. With `IRQ_PULSE`=1, `irq_o` is high for exactly the first cycle in which `pend_o` reads 0. `irq_o` is never high while `pend_o` is 1.
- R5: `scl_hold_o` is 1 exactly while `pend_o` is 0.
- R6: `pend_o` reads 1 after reset, after `if_en`=0, after a `bus_stop` strobe, after a suppressed START, and after a `cpu_wr_data` write with no clearing event in the same cycle.
- R7: In slave receive mode, an `addr_byte` strobe clears `pend_o`. With `addr_free`=0 this happens only when `addr_match`=1. With `addr_free`=1 it happens regardless of `addr_match`.
- R8: `busy_o` is set by `bus_start` and cleared by `bus_stop`, with STOP winning if both arrive together. It reads 0 after reset and is held at 0 while `if_en`=0.
- R9: A status write (`cpu_wr_stat`) loads `wr_bb` into `busy_o` only when `wr_mst`=1 and `wr_trx`=1. Otherwise `busy_o` is unchanged.
- R10: A START request is a status write with `wr_mst`, `wr_trx` and `wr_bb` all 1. If `busy_o` is 1 when it arrives, the request is suppressed. `start_go_o` stays 0, `pend_o` goes to 1, and `mst_o` and `trx_o` go to 0. `start_block_o` follows `busy_o`.
- R11: A START request with `busy_o`=0 and `if_en`=1 gives a one-cycle `start_go_o` pulse in the cycle after the write, and sets `mst_o`, `trx_o` and `busy_o` to 1.
- R12: In slave receive mode with `addr_free`=0, an `addr_byte` strobe with `addr_match`=1 loads `rx_rw` into `trx_o`.
- R13: `trx_o` clears on `bus_stop`, and also on `bus_start` or `ack_missing` while `mst_o`=0. `mst_o` clears on `bus_stop`. Both reset to 0.
- R14: Priority within one clock is reset first, then bus events, then CPU writes. So `byte_done` beats `cpu_wr_data`, and `bus_stop` beats a status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_en | input | 1 | Interface enable |
| addr_free | input | 1 | Address-free mode select |
| bus_start | input | 1 | START detected strobe |
| bus_stop | input | 1 | STOP detected strobe |
| byte_done | input | 1 | Falling edge of the last SCL of a byte, ACK clock included |
| ack_missing | input | 1 | No ACK returned strobe |
| sda_mismatch | input | 1 | SDA seen low while this side drives high |
| addr_byte | input | 1 | Slave address byte received strobe |
| addr_match | input | 1 | Own or general-call address matched, valid with addr_byte |
| rx_rw | input | 1 | Received R/W bit, valid with addr_byte |
| cpu_wr_data | input | 1 | CPU write to the data shift register |
| cpu_wr_stat | input | 1 | CPU write to the status fields |
| wr_mst | input | 1 | Written master bit |
| wr_trx | input | 1 | Written direction bit |
| wr_bb | input | 1 | Written busy bit (START request) |
| mst_o | output | 1 | Master role flag |
| trx_o | output | 1 | Transmit direction flag |
| busy_o | output | 1 | Bus busy flag |
| pend_o | output | 1 | Pending flag, 0 while a byte awaits service |
| arb_lost_o | output | 1 | Arbitration lost flag |
| irq_o | output | 1 | Interrupt request |
| scl_hold_o | output | 1 | Request to hold SCL low |
| start_go_o | output | 1 | START generation pulse |
| start_block_o | output | 1 | START generation inhibited |

## Verification
Two functions can land in the same cycle: a bus event that clears a flag and a CPU write that sets it. The bench provokes this with vectors that strobe `byte_done` together with a data write, and `bus_stop` together with a master-transmit status write. The outcome is judged against R14: the bus event must decide the flag. Arbitration loss combined with a pending byte end is also stepped cycle by cycle, to show that the direction bit drops before the master bit does.

// File: rtl/i2cst_pkg.sv
package i2cst_pkg;

   // Fields carried by a CPU status write.
   typedef struct packed {
      logic mst;
      logic trx;
      logic bb;
   } stat_wr_t;

   // A START request is a master-transmit write with the busy bit set.
   function automatic logic is_start_req(input logic wr_stat, input stat_wr_t w);
      return wr_stat & w.mst & w.trx & w.bb;
   endfunction

   // A busy write is honoured only for master-transmit writes.
   function automatic logic is_mtx_write(input logic wr_stat, input stat_wr_t w);
      return wr_stat & w.mst & w.trx;
   endfunction

endpackage

// File: rtl/i2cst_busy.sv
module i2cst_busy
   import i2cst_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     en,
   input  logic     ev_start,
   input  logic     ev_stop,
   input  logic     wr_stat,
   input  stat_wr_t wr,
   output logic     busy_q,
   output logic     guard,
   output logic     start_ok,
   output logic     start_go
);
   logic req;

   assign req      = is_start_req(wr_stat, wr);
   assign guard    = req & busy_q;
   assign start_ok = req & ~busy_q & en;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         start_go <= 1'b0;
      end else begin
         start_go <= start_ok;
         if (!en)
            busy_q <= 1'b0;
         else if (ev_stop)
            busy_q <= 1'b0;
         else if (ev_start)
            busy_q <= 1'b1;
         else if (is_mtx_write(wr_stat, wr) && !guard)
            busy_q <= wr.bb;
      end
   end
endmodule

// File: rtl/i2cst_mode.sv
module i2cst_mode
   import i2cst_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     ev_start,
   input  logic     ev_stop,
   input  logic     ev_byte_done,
   input  logic     ev_ack_miss,
   input  logic     ev_mismatch,
   input  logic     ev_addr_byte,
   input  logic     addr_match,
   input  logic     rx_rw,
   input  logic     addr_free,
   input  logic     wr_stat,
   input  stat_wr_t wr,
   input  logic     guard,
   input  logic     start_ok,
   output logic     mst_q,
   output logic     trx_q,
   output logic     al_q,
   output logic     slv_rx
);
   logic al_now, trx_clr, mst_clr, rw_load;

   assign slv_rx  = ~mst_q & ~trx_q;
   assign al_now  = ev_mismatch & mst_q & trx_q;
   assign trx_clr = al_now | ev_stop | guard | (~mst_q & (ev_start | ev_ack_miss));
   assign mst_clr = ev_stop | guard | (ev_byte_done & (al_q | al_now));
   assign rw_load = slv_rx & ~addr_free & ev_addr_byte & addr_match;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mst_q <= 1'b0;
         trx_q <= 1'b0;
         al_q  <= 1'b0;
      end else begin
         if (al_now)
            al_q <= 1'b1;
         else if (start_ok)
            al_q <= 1'b0;

         if (mst_clr)
            mst_q <= 1'b0;
         else if (wr_stat)
            mst_q <= wr.mst;

         if (trx_clr)
            trx_q <= 1'b0;
         else if (rw_load)
            trx_q <= rx_rw;
         else if (wr_stat)
            trx_q <= wr.trx;
      end
   end
endmodule

// File: rtl/i2cst_pend.sv
module i2cst_pend #(
   parameter int IRQ_PULSE = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic ev_stop,
   input  logic guard,
   input  logic ev_byte_done,
   input  logic ev_addr_byte,
   input  logic addr_match,
   input  logic addr_free,
   input  logic slv_rx,
   input  logic cpu_wr_data,
   output logic pend_q,
   output logic irq,
   output logic scl_hold
);
   logic pend_d, addr_clr;

   assign addr_clr = slv_rx & ev_addr_byte & (addr_free | addr_match);

   always_comb begin
      if (!en || ev_stop || guard)
         pend_d = 1'b1;
      else if (ev_byte_done || addr_clr)
         pend_d = 1'b0;
      else if (cpu_wr_data)
         pend_d = 1'b1;
      else
         pend_d = pend_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= 1'b1;
      else        pend_q <= pend_d;
   end

   assign scl_hold = ~pend_q;

   generate
      if (IRQ_PULSE != 0) begin : g_pulse
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= pend_q & ~pend_d;
         end
         assign irq = irq_q;
      end else begin : g_level
         assign irq = ~pend_q & en;
      end
   endgenerate
endmodule

// File: rtl/i2c_flag_ctrl.sv
module i2c_flag_ctrl
   import i2cst_pkg::*;
#(
   parameter int IRQ_PULSE = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic if_en,
   input  logic addr_free,
   input  logic bus_start,
   input  logic bus_stop,
   input  logic byte_done,
   input  logic ack_missing,
   input  logic sda_mismatch,
   input  logic addr_byte,
   input  logic addr_match,
   input  logic rx_rw,
   input  logic cpu_wr_data,
   input  logic cpu_wr_stat,
   input  logic wr_mst,
   input  logic wr_trx,
   input  logic wr_bb,
   output logic mst_o,
   output logic trx_o,
   output logic busy_o,
   output logic pend_o,
   output logic arb_lost_o,
   output logic irq_o,
   output logic scl_hold_o,
   output logic start_go_o,
   output logic start_block_o
);
   generate
      if (IRQ_PULSE != 0 && IRQ_PULSE != 1) begin : g_bad_param
         initial $fatal(1, "IRQ_PULSE must be 0 or 1");
      end
   endgenerate

   stat_wr_t wr;
   logic     guard, start_ok, slv_rx;

   assign wr = '{mst: wr_mst, trx: wr_trx, bb: wr_bb};

   i2cst_busy u_busy (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (if_en),
      .ev_start (bus_start),
      .ev_stop  (bus_stop),
      .wr_stat  (cpu_wr_stat),
      .wr       (wr),
      .busy_q   (busy_o),
      .guard    (guard),
      .start_ok (start_ok),
      .start_go (start_go_o)
   );

   i2cst_mode u_mode (
      .clk          (clk),
      .rst_n        (rst_n),
      .ev_start     (bus_start),
      .ev_stop      (bus_stop),
      .ev_byte_done (byte_done),
      .ev_ack_miss  (ack_missing),
      .ev_mismatch  (sda_mismatch),
      .ev_addr_byte (addr_byte),
      .addr_match   (addr_match),
      .rx_rw        (rx_rw),
      .addr_free    (addr_free),
      .wr_stat      (cpu_wr_stat),
      .wr           (wr),
      .guard        (guard),
      .start_ok     (start_ok),
      .mst_q        (mst_o),
      .trx_q        (trx_o),
      .al_q         (arb_lost_o),
      .slv_rx       (slv_rx)
   );

   i2cst_pend #(.IRQ_PULSE(IRQ_PULSE)) u_pend (
      .clk          (clk),
      .rst_n        (rst_n),
      .en           (if_en),
      .ev_stop      (bus_stop),
      .guard        (guard),
      .ev_byte_done (byte_done),
      .ev_addr_byte (addr_byte),
      .addr_match   (addr_match),
      .addr_free    (addr_free),
      .slv_rx       (slv_rx),
      .cpu_wr_data  (cpu_wr_data),
      .pend_q       (pend_o),
      .irq          (irq_o),
      .scl_hold     (scl_hold_o)
   );

   assign start_block_o = busy_o;
endmodule

// File: rtl/i2c_flag_ctrl_chk.sv
module i2c_flag_ctrl_chk #(
   parameter int IRQ_PULSE = 1
) (
   input logic clk,
   input logic rst_n,
   input logic if_en,
   input logic addr_free,
   input logic bus_start,
   input logic bus_stop,
   input logic byte_done,
   input logic ack_missing,
   input logic sda_mismatch,
   input logic addr_byte,
   input logic addr_match,
   input logic rx_rw,
   input logic cpu_wr_data,
   input logic cpu_wr_stat,
   input logic wr_mst,
   input logic wr_trx,
   input logic wr_bb,
   input logic mst_o,
   input logic trx_o,
   input logic busy_o,
   input logic pend_o,
   input logic arb_lost_o,
   input logic irq_o,
   input logic scl_hold_o,
   input logic start_go_o,
   input logic start_block_o
);
   logic req;
   assign req = cpu_wr_stat & wr_mst & wr_trx & wr_bb;

   AST_AL_DROPS_TRX: assert property (@(posedge clk) disable iff (!rst_n)
      (mst_o && trx_o && sda_mismatch) |=> (arb_lost_o && !trx_o)); // R1

   AST_MST_KEEPS_TILL_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (mst_o && trx_o && sda_mismatch && !byte_done && !bus_stop && !cpu_wr_stat) |=> mst_o); // R2

   AST_IRQ_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> !pend_o); // R4

   generate
      if (IRQ_PULSE != 0) begin : g_pulse_chk
         AST_IRQ_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pend_o) |-> irq_o); // R4
      end
   endgenerate

   AST_HOLD_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (if_en && byte_done && !bus_stop && !(req && busy_o)) |=> scl_hold_o); // R5

   AST_STOP_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
      (if_en && bus_stop) |=> (pend_o && !trx_o && !mst_o && !busy_o)); // R13

   AST_DISABLE_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
      !if_en |=> (!busy_o && pend_o)); // R6

   AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (if_en && bus_start && !bus_stop) |=> busy_o); // R8

   AST_GUARD_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
      (req && busy_o) |=> (!start_go_o && pend_o && !mst_o && !trx_o)); // R10

   AST_BLOCK_FOLLOWS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (start_go_o |-> !$past(busy_o))); // R11

   AST_SLAVE_RW_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      (!mst_o && !trx_o && !addr_free && addr_byte && addr_match
       && !bus_stop && !bus_start && !ack_missing) |=> (trx_o == $past(rx_rw))); // R12
endmodule

bind i2c_flag_ctrl i2c_flag_ctrl_chk #(.IRQ_PULSE(IRQ_PULSE)) chk_i (.*);

// File: tb/i2c_flag_ctrl_tb_top.sv
`timescale 1ns/1ps
module i2c_flag_ctrl_tb_top;
   logic clk = 1'b0;
   logic rst_n;
   logic if_en, addr_free, bus_start, bus_stop, byte_done, ack_missing, sda_mismatch;
   logic addr_byte, addr_match, rx_rw, cpu_wr_data, cpu_wr_stat, wr_mst, wr_trx, wr_bb;
   logic mst_o, trx_o, busy_o, pend_o, arb_lost_o, irq_o, scl_hold_o, start_go_o, start_block_o;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   i2c_flag_ctrl #(.IRQ_PULSE(1)) dut_i (.*);

   // vector: {req tag[3:0], inputs[14:0], expected[7:0]}
   // inputs: en start stop bdone ackmiss mism abyte amatch rw afree wrdata wrstat wmst wtrx wbb
   // expected: mst trx busy pend al irq hold go
   localparam int NV = 24;
   localparam logic [26:0] VEC [NV] = '{
      {4'd11, 15'b100000000001111, 8'b11110001}, // R11 accepted START
      {4'd6,  15'b100000000010000, 8'b11110000}, // R6 data write keeps pend
      {4'd4,  15'b100100000000000, 8'b11100110}, // R4 byte end, irq pulse
      {4'd5,  15'b100000000000000, 8'b11100010}, // R5 hold while pending
      {4'd6,  15'b100000000010000, 8'b11110000}, // R6 data write releases
      {4'd1,  15'b100001000000000, 8'b10111000}, // R1 arbitration lost
      {4'd2,  15'b100000000000000, 8'b10111000}, // R2 master kept
      {4'd3,  15'b100100000000000, 8'b00101110}, // R3 byte end: slave receive
      {4'd6,  15'b100000000010000, 8'b00111000}, // R6 release
      {4'd12, 15'b100000111000000, 8'b01101110}, // R12 own address, read
      {4'd13, 15'b100010000000000, 8'b00101010}, // R13 ack missing in slave
      {4'd13, 15'b101000000000000, 8'b00011000}, // R13 stop
      {4'd8,  15'b110000000000000, 8'b00111000}, // R8 start sets busy
      {4'd10, 15'b100000000001111, 8'b00111000}, // R10 suppressed START
      {4'd7,  15'b100000100100000, 8'b00101110}, // R7 address-free clear
      {4'd6,  15'b000000000000000, 8'b00011000}, // R6 disable
      {4'd8,  15'b010000000000000, 8'b00011000}, // R8 busy held 0 when disabled
      {4'd9,  15'b100000000001001, 8'b00011000}, // R9 busy write ignored
      {4'd7,  15'b100000100000000, 8'b00011000}, // R7 no match, no clear
      {4'd11, 15'b100000000001111, 8'b11110001}, // R11 START, al cleared
      {4'd14, 15'b100100000010000, 8'b11100110}, // R14 byte end beats data write
      {4'd14, 15'b101000000001110, 8'b00010000}, // R14 stop beats status write
      {4'd9,  15'b100000000001110, 8'b11010000}, // R9 busy written 0
      {4'd1,  15'b100001000000000, 8'b10011000}  // R1 loss again
   };

   task automatic drive(input logic [14:0] v);
      {if_en, bus_start, bus_stop, byte_done, ack_missing, sda_mismatch, addr_byte,
       addr_match, rx_rw, addr_free, cpu_wr_data, cpu_wr_stat, wr_mst, wr_trx, wr_bb} = v;
   endtask

   task automatic check(input int tag, input logic [7:0] exp);
      logic [7:0] act;
      act = {mst_o, trx_o, busy_o, pend_o, arb_lost_o, irq_o, scl_hold_o, start_go_o};
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL R%0d: flags %b expected %b", tag, act, exp);
      end
   endtask

   initial begin
      #400000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      drive(15'b100000000000000);
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(6, 8'b00010000);  // R6 R8 R13 reset state
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         drive(VEC[i][22:8]);
         @(posedge clk);
         #1;
         check(int'(VEC[i][26:23]), VEC[i][7:0]);
      end

      // directed: reset while master and pending, R6 R8 R13
      @(negedge clk);
      drive(15'b100000000001111);
      @(negedge clk);
      drive(15'b100100000000000);
      @(negedge clk);
      drive(15'b100000000000000);
      rst_n = 1'b0;
      @(posedge clk);
      #1;
      check(13, 8'b00010000); // R13 reset clears mst/trx, R8 busy, R6 pend
      @(negedge clk);
      rst_n = 1'b1;
      // start_block follows busy, R10
      drive(15'b110000000000000);
      @(posedge clk);
      #1;
      n_chk++;
      if (start_block_o !== 1'b1) begin
         n_bad++;
         $display("FAIL R10: start_block %b expected 1", start_block_o);
      end
      // start and stop together: stop wins, R8
      @(negedge clk);
      drive(15'b111000000000000);
      @(posedge clk);
      #1;
      check(8, 8'b00010000);

      @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule